// File: doc/BRIEF.md
# Degradable Two-Mode FIR Filter

This block is a direct-form FIR filter that can fall back to a reduced form. In standard operation it convolves the incoming signed samples with a full set of eight coefficients. When a temperature code shows that the die is too hot, it switches to a backup form. The backup form keeps four taps, takes its coefficients from a separate bank, and forces the four upper taps to contribute nothing.

A hysteresis comparator chooses the mode. The comparator holds two programmable thresholds, so the mode does not chatter while the code sits between them. One configuration port writes either coefficient bank or either threshold. The products are summed by two half-width sub-adders, one pipeline register and a final adder. The sum is then rounded and clipped to a 16-bit signed result, which leaves the block exactly two cycles after its sample enters.

Top module: `degradable_fir`

## Requirements
- R1: After reset, outValid is low, backupMode is low (standard mode), every coefficient is zero, the high threshold is 135 and the low threshold is 125.
- R2: In standard mode a sample x[n] yields round(sum over k=0..7 of std[k]*x[n-k]). Here round(a) is (a+128)>>>8, saturated to 16 bits, and x[n-k] counts earlier accepted samples (zero since reset).
- R3: In backup mode the result uses backup coefficients bk[0..3] on taps 0..3, and taps 4..7 contribute zero. The sum of taps 4..7 is zero in the pipeline stage after such a sample.
- R4: If tempCode (unsigned 8 bits) is strictly greater than the high threshold, backupMode is high from the next cycle on. A code equal to the high threshold does not trigger this.
- R5: If tempCode is at or below the low threshold, backupMode goes low on the next cycle. Strictly between the two thresholds, backupMode keeps its value.
- R6: Each cycle with inValid high produces exactly one cycle with outValid high, two cycles later. No other cycle has outValid high.
- R7: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R8: The configuration port writes when cfgWe is high. cfgTarget 0 writes std[cfgAddr] and cfgTarget 1 writes bk[cfgAddr], with cfgData taken as a signed 12-bit value. A write made in the same cycle as a sample applies from the following sample.
- R9: cfgTarget 2 writes a threshold from cfgData[7:0]: the high threshold when cfgAddr[0] is 0, the low threshold when it is 1. The new value applies to the mode decision from the next cycle.
- R10: A backup-bank write with cfgAddr of 4 or more has no effect, and so does any write with cfgTarget 3.
- R11: A sample is computed with the mode held in the cycle it is accepted. A mode change does not clear the delay line, so older samples stay in the taps that are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | 12 | Signed input sample |
| tempCode | input | 8 | Unsigned temperature code |
| cfgWe | input | 1 | Configuration write enable |
| cfgTarget | input | 2 | 0 std bank, 1 backup bank, 2 thresholds, 3 none |
| cfgAddr | input | 3 | Tap index or threshold select |
| cfgData | input | 12 | Coefficient or threshold value |
| outValid | output | 1 | Result strobe |
| outSample | output | 16 | Signed rounded, saturated result |
| backupMode | output | 1 | High while the backup form is active |

## Verification
The assertions assume that inValid is held low during reset. They also assume that tempCode and the configuration inputs are always known. The mode properties further assume that the low threshold stays below the high one, because otherwise the "hold" band is empty and the two switching rules overlap. The stimulus enforces this: every random threshold write puts the high value in 130..150 and the low value in 110..129. The random temperature codes cover both sides of each threshold and the band between them.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef struct packed {
    logic sampleTake;
    logic backupSel;
  } fir_strobe_t;

  localparam logic [1:0] TGT_STD = 2'd0;
  localparam logic [1:0] TGT_BK  = 2'd1;
  localparam logic [1:0] TGT_THR = 2'd2;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl import fir_pkg::*; #(
  parameter int N = 8,
  parameter int M = 4,
  parameter int C_W = 12,
  parameter int T_W = 8,
  parameter int HI_DEFAULT = 135,
  parameter int LO_DEFAULT = 125,
  localparam int ADDR_W = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [T_W-1:0]            tempCode,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgTarget,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [C_W-1:0]            cfgData,
  output fir_strobe_t               strobe,
  output logic [N-1:0][C_W-1:0]     coefVec,
  output logic                      modeBackup
);
  logic [C_W-1:0] stdBank [N];
  logic [C_W-1:0] bkBank  [M];
  logic [T_W-1:0] thrHigh, thrLow;

  // Coefficient banks: one write decoder per entry
  for (genvar k = 0; k < N; k++) begin : g_std
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stdBank[k] <= '0;
      else if (cfgWe && cfgTarget == TGT_STD && cfgAddr == ADDR_W'(k)) stdBank[k] <= cfgData;
    end
  end

  for (genvar k = 0; k < M; k++) begin : g_bk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bkBank[k] <= '0;
      else if (cfgWe && cfgTarget == TGT_BK && cfgAddr == ADDR_W'(k)) bkBank[k] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrHigh <= T_W'(HI_DEFAULT);
      thrLow  <= T_W'(LO_DEFAULT);
    end else if (cfgWe && cfgTarget == TGT_THR) begin
      if (cfgAddr[0]) thrLow  <= cfgData[T_W-1:0];
      else            thrHigh <= cfgData[T_W-1:0];
    end
  end

  // Hysteresis comparator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeBackup <= 1'b0;
    else if (tempCode > thrHigh) modeBackup <= 1'b1;
    else if (tempCode <= thrLow) modeBackup <= 1'b0;
  end

  // Bank selection per tap; upper taps are gated in the datapath
  for (genvar k = 0; k < N; k++) begin : g_sel
    if (k < M) begin : g_low
      assign coefVec[k] = modeBackup ? bkBank[k] : stdBank[k];
    end else begin : g_high
      assign coefVec[k] = stdBank[k];
    end
  end

  assign strobe.sampleTake = inValid;
  assign strobe.backupSel  = modeBackup;

  p_hot_enter_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode > thrHigh) |=> modeBackup);
  p_cold_leave_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode <= thrLow && tempCode <= thrHigh) |=> !modeBackup);
  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode <= thrHigh && tempCode > thrLow) |=> $stable(modeBackup));
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath import fir_pkg::*; #(
  parameter int N = 8,
  parameter int M = 4,
  parameter int S_W = 12,
  parameter int C_W = 12,
  parameter int O_W = 16,
  parameter int FRAC = 8,
  localparam int PROD_W = S_W + C_W,
  localparam int HALF_W = PROD_W + $clog2(N/2),
  localparam int RND_W  = HALF_W + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fir_strobe_t               strobe,
  input  logic signed [S_W-1:0]     inSample,
  input  logic [N-1:0][C_W-1:0]     coefVec,
  output logic                      outValid,
  output logic signed [O_W-1:0]     outSample
);
  localparam logic signed [RND_W-1:0] HALF_LSB = RND_W'(2 ** (FRAC - 1));
  localparam logic signed [RND_W-1:0] OUT_MAX  = RND_W'(2 ** (O_W - 1) - 1);
  localparam logic signed [RND_W-1:0] OUT_MIN  = -RND_W'(2 ** (O_W - 1));

  logic signed [S_W-1:0]    dly [N-1];
  logic signed [S_W-1:0]    tapS [N];
  logic signed [C_W-1:0]    coefS [N];
  logic signed [PROD_W-1:0] prod [N];
  logic [N-1:0]             tapOn;
  logic signed [HALF_W-1:0] sumLoC, sumHiC, sumLo, sumHi;
  logic                     s1Valid;
  logic signed [RND_W-1:0]  totalC, shiftC;

  // Delay line: shifts on every accepted sample, never flushed
  for (genvar k = 0; k < N - 1; k++) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dly[k] <= '0;
      else if (strobe.sampleTake) begin
        if (k == 0) dly[k] <= inSample;
        else        dly[k] <= dly[k-1];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_tap
    if (k == 0) begin : g_in
      assign tapS[k] = inSample;
    end else begin : g_reg
      assign tapS[k] = dly[k-1];
    end
    if (k < M) begin : g_keep
      assign tapOn[k] = 1'b1;
    end else begin : g_gate
      assign tapOn[k] = !strobe.backupSel;
    end
    assign coefS[k] = coefVec[k];
    assign prod[k]  = tapOn[k] ? PROD_W'(tapS[k]) * PROD_W'(coefS[k]) : '0;
  end

  // Two sub-adders over the lower and upper halves of the taps
  always_comb begin
    sumLoC = '0;
    sumHiC = '0;
    for (int k = 0; k < N / 2; k++) sumLoC = sumLoC + HALF_W'(prod[k]);
    for (int k = N / 2; k < N; k++) sumHiC = sumHiC + HALF_W'(prod[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumLo   <= '0;
      sumHi   <= '0;
      s1Valid <= 1'b0;
    end else begin
      s1Valid <= strobe.sampleTake;
      if (strobe.sampleTake) begin
        sumLo <= sumLoC;
        sumHi <= sumHiC;
      end
    end
  end

  // Final adder, round half up, saturate
  assign totalC = RND_W'(sumLo) + RND_W'(sumHi) + HALF_LSB;
  assign shiftC = totalC >>> FRAC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) begin
        if (shiftC > OUT_MAX)      outSample <= OUT_MAX[O_W-1:0];
        else if (shiftC < OUT_MIN) outSample <= OUT_MIN[O_W-1:0];
        else                       outSample <= shiftC[O_W-1:0];
      end
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleTake |=> ##1 outValid);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.sampleTake, 2));
  p_upper_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleTake && strobe.backupSel) |=> (sumHi == '0));
endmodule

// File: rtl/degradable_fir.sv
module degradable_fir import fir_pkg::*; #(
  parameter int N = 8,
  parameter int M = 4,
  parameter int S_W = 12,
  parameter int C_W = 12,
  parameter int O_W = 16,
  parameter int T_W = 8,
  parameter int FRAC = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic signed [S_W-1:0] inSample,
  input  logic [T_W-1:0]        tempCode,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgTarget,
  input  logic [$clog2(N)-1:0]  cfgAddr,
  input  logic [C_W-1:0]        cfgData,
  output logic                  outValid,
  output logic signed [O_W-1:0] outSample,
  output logic                  backupMode
);
  fir_strobe_t              strobe;
  logic [N-1:0][C_W-1:0]    coefVec;

  fir_ctrl #(.N(N), .M(M), .C_W(C_W), .T_W(T_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tempCode(tempCode),
    .cfgWe(cfgWe), .cfgTarget(cfgTarget), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .coefVec(coefVec), .modeBackup(backupMode)
  );

  fir_datapath #(.N(N), .M(M), .S_W(S_W), .C_W(C_W), .O_W(O_W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSample(inSample),
    .coefVec(coefVec), .outValid(outValid), .outSample(outSample)
  );
endmodule

// File: tb/tb_degradable_fir.sv
module tb_degradable_fir;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [11:0] inSample = '0;
  logic [7:0] tempCode = 8'd100;
  logic cfgWe = 1'b0;
  logic [1:0] cfgTarget = '0;
  logic [2:0] cfgAddr = '0;
  logic [11:0] cfgData = '0;
  logic outValid;
  logic signed [15:0] outSample;
  logic backupMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phaseTag = "";

  // reference state
  int stdC [8];
  int bkC [4];
  int hist [7];
  int thrH = 135, thrL = 125;
  bit mMode = 0;
  bit p1V = 0, p2V = 0;
  int p1Val = 0, p2Val = 0;
  string p1Tag = "", p2Tag = "";

  always #10 clk = ~clk;

  degradable_fir dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .tempCode(tempCode), .cfgWe(cfgWe), .cfgTarget(cfgTarget), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .outValid(outValid), .outSample(outSample), .backupMode(backupMode)
  );

  function automatic int roundSat(longint acc, output bit sat);
    longint r = (acc + 128) >>> 8;
    sat = 0;
    if (r > 32767) begin r = 32767; sat = 1; end
    if (r < -32768) begin r = -32768; sat = 1; end
    return int'(r);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: model the edge, advance, then compare outputs
  task automatic step();
    bit nV = 0;
    int nVal = 0;
    string nTag = "";
    if (inValid) begin
      longint acc = 0;
      bit sat;
      for (int k = 0; k < 8; k++) begin
        int t = (k == 0) ? int'(inSample) : hist[k-1];
        int c = mMode ? ((k < 4) ? bkC[k] : 0) : stdC[k];
        acc += longint'(t) * longint'(c);
      end
      nVal = roundSat(acc, sat);
      nV = 1;
      if (phaseTag != "") nTag = phaseTag;
      else if (sat) nTag = "R7";
      else nTag = mMode ? "R3" : "R2";
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'(inSample);
    end
    if (cfgWe) begin
      if (cfgTarget == 2'd0) stdC[cfgAddr] = int'($signed(cfgData));
      else if (cfgTarget == 2'd1 && cfgAddr < 3'd4) bkC[cfgAddr[1:0]] = int'($signed(cfgData));
    end
    if (int'(tempCode) > thrH) mMode = 1;
    else if (int'(tempCode) <= thrL) mMode = 0;
    if (cfgWe && cfgTarget == 2'd2) begin
      if (cfgAddr[0]) thrL = int'(cfgData[7:0]);
      else thrH = int'(cfgData[7:0]);
    end
    p2V = p1V; p2Val = p1Val; p2Tag = p1Tag;
    p1V = nV; p1Val = nVal; p1Tag = nTag;
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    cfgWe = 0;
    check("R6 outValid", int'(outValid), int'(p2V));
    if (p2V && outValid) check(p2Tag, int'(outSample), p2Val);
    check(mMode ? "R4 mode" : "R5 mode", int'(backupMode), int'(mMode));
  endtask

  task automatic feed(int x);
    inValid = 1;
    inSample = 12'(x);
    step();
  endtask

  task automatic wr(int tgt, int addr, int data);
    cfgWe = 1;
    cfgTarget = 2'(tgt);
    cfgAddr = 3'(addr);
    cfgData = 12'(data);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) stdC[k] = 0;
    for (int k = 0; k < 4; k++) bkC[k] = 0;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1 outValid", int'(outValid), 0);
    check("R1 mode", int'(backupMode), 0);
    phaseTag = "R1";
    feed(1000); step(); step();
    phaseTag = "";

    // R8: load std bank; write and sample in the same cycle
    phaseTag = "R8";
    for (int k = 0; k < 8; k++) wr(0, k, (k + 1) * 37 - 100);
    cfgWe = 1; cfgTarget = 0; cfgAddr = 0; cfgData = 12'd500;
    inValid = 1; inSample = 12'sd300;
    step();
    feed(-700); step(); step();
    phaseTag = "";

    // R2: random standard-mode samples
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 3) != 0) feed($urandom_range(0, 4095) - 2048);
      else step();
    end
    step(); step();

    // R10: ignored backup addresses and target 3, then real backup bank
    for (int k = 0; k < 4; k++) wr(1, k, $urandom_range(0, 4095) - 2048);
    wr(1, 5, 1999); wr(1, 7, -1999); wr(3, 0, 1234); wr(3, 2, 77);

    // R1/R4: default high threshold, boundary 135 does not trigger
    tempCode = 8'd135; step(); step();
    tempCode = 8'd136; step();
    // R5: band hold
    tempCode = 8'd130; step(); step();
    // R3: backup samples
    for (int i = 0; i < 30; i++) feed($urandom_range(0, 4095) - 2048);
    step(); step();
    // R5: leave at the low threshold
    tempCode = 8'd126; step();
    tempCode = 8'd125; step(); step();

    // R11: mode flips at the edge a sample is taken; delay line kept
    phaseTag = "R11";
    tempCode = 8'd200; feed(1500);
    feed(-1200); feed(900);
    tempCode = 8'd50; feed(333);
    feed(-44); feed(2047); step(); step();
    phaseTag = "";

    // R9: thresholds moved through the port
    phaseTag = "R9";
    wr(2, 0, 60); wr(2, 1, 40);
    tempCode = 8'd61; step(); feed(100);
    tempCode = 8'd50; step(); step();
    tempCode = 8'd40; step(); feed(-100); step(); step();
    wr(2, 0, 135); wr(2, 1, 125);
    tempCode = 8'd100; step();
    phaseTag = "";

    // R7: saturation both ways
    for (int k = 0; k < 8; k++) wr(0, k, 2047);
    for (int i = 0; i < 9; i++) feed(2047);
    for (int i = 0; i < 9; i++) feed(-2048);
    step(); step();

    // Mixed random stimulus
    for (int i = 0; i < 4000; i++) begin
      tempCode = 8'($urandom_range(110, 150));
      if ($urandom_range(0, 9) == 0) begin
        int tgt = $urandom_range(0, 3);
        cfgWe = 1; cfgTarget = 2'(tgt); cfgAddr = 3'($urandom_range(0, 7));
        if (tgt == 2) cfgData = cfgAddr[0] ? 12'($urandom_range(110, 129)) : 12'($urandom_range(130, 150));
        else cfgData = 12'($urandom_range(0, 4095));
      end
      if ($urandom_range(0, 1) == 1) begin
        inValid = 1;
        inSample = 12'($urandom_range(0, 4095));
      end
      step();
    end
    step(); step();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule